// File: doc/BRIEF.md
# Event-Selected Performance Counter Bank

This block holds six 32-bit performance counters next to a processor pipeline. In each clock cycle it receives the number of instructions retired in that cycle, from 0 to 7, and a cycle tick. Two control registers decide what each counter does. The mode register holds the freeze bits and two overflow-enable bits. The event register holds one 8-bit event code for each of counters 1 to 4. Counters 5 and 6 have fixed functions: counter 5 counts instructions and counter 6 counts cycles.

A counter can have overflow enabled. If an increment takes such a counter to the sign-bit value 0x80000000 or past it, the counter stops at exactly 0x80000000 and the block raises an overflow pulse. If overflow is not enabled, the counter wraps modulo 2^32. Software reaches every counter and both control registers through a single-cycle register port.

Top module: `perf_counter_bank`

## Requirements
- R1: After synchronous reset, all six counters, the mode register and the event register read 0, and `ovf_pulse` is low.
- R2: Register map on `reg_addr`: addresses 0 to 5 are counters 1 to 6, address 6 is the mode register and address 7 is the event register. Any other address reads 0, and a write to it has no effect. Mode bits: bit 0 freezes everything, bit 1 freezes counters 1 to 4, bit 2 freezes counters 5 and 6, bit 3 enables overflow for counter 1, and bit 4 enables overflow for counters 2 to 6. Mode writes keep bits [4:0]. Event byte [8k-1:8k-8] is the code for counter k. `reg_rdata` shows the addressed register combinationally. A control write takes effect from the next cycle.
- R3: While mode bit 0 is set, no counter advances, whether by instructions or by cycles.
- R4: Counters 1 to 4 advance only while mode bit 1 is clear and the whole event register is nonzero.
- R5: Counter 1 adds the instruction count for codes 0x02 and 0xFE. It adds 1 per cycle tick for codes 0x1E and 0xF0.
- R6: Counters 2 and 3 add the instruction count for code 0x02 and add one per tick for code 0x1E.
- R7: Counter 4 adds one per tick for code 0x1E. It adds the instruction count for code 0x02 at all times, and for code 0xFA only while `run_latch` is high.
- R8: Counter 5 adds the instruction count and counter 6 adds one per tick, both only while mode bit 2 is clear. No other code moves any counter.
- R9: If an increment that is not zero takes a counter with overflow enabled to 0x80000000 or higher, the counter becomes exactly 0x80000000. In that case `ovf_pulse` is high in the next cycle, one cycle for each such increment. Counter 1 uses mode bit 3, and counters 2 to 6 use mode bit 4.
- R10: A counter whose overflow is not enabled wraps modulo 2^32 and produces no pulse.
- R11: A software write to a counter stores only bits [31:0] of `reg_wdata`. It overrides any increment of that counter in the same cycle, and that counter gives no pulse for that cycle.
- R12: The counter value updates at the clock edge that ends the cycle in which its increment is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_cnt | input | 3 | Instructions retired this cycle |
| cyc_tick | input | 1 | Cycle tick |
| run_latch | input | 1 | External run indication used by counter 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ovf_pulse | output | 1 | Overflow pulse |

## Verification
The hardest state to reach is a counter just below 0x80000000 under an event code that moves it, with the matching overflow-enable bit set. Random counting alone would need about 2^31 increments to get there. The stimulus therefore writes values within a few counts of the threshold, both in directed cases and as a biased part of the random writes. At the same time it randomizes the event codes, the freeze bits and both enable bits, so clamping, wrapping and write-over-increment collisions all appear on every counter.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int NUM_CTR  = 6;
    localparam int NUM_SEL  = 4;
    localparam int CTR_W    = 32;
    localparam int EVT_W    = 8;
    localparam int INSN_W   = 3;
    localparam int ADDR_W   = 4;
    localparam int WDATA_W  = 64;
    localparam int SEL_W    = NUM_SEL * EVT_W;
    localparam int INC_W    = INSN_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(NUM_CTR);
    localparam logic [ADDR_W-1:0] ADDR_EVENT = ADDR_W'(NUM_CTR + 1);

    localparam logic [EVT_W-1:0] EV_INSN     = 8'h02;
    localparam logic [EVT_W-1:0] EV_CYC      = 8'h1E;
    localparam logic [EVT_W-1:0] EV_INSN_ALT = 8'hFE;
    localparam logic [EVT_W-1:0] EV_CYC_ALT  = 8'hF0;
    localparam logic [EVT_W-1:0] EV_RUN_INSN = 8'hFA;

    typedef struct packed {
        logic ovf_en_rest;
        logic ovf_en_first;
        logic frz_56;
        logic frz_14;
        logic frz_all;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {SRC_NONE, SRC_INSN, SRC_CYC} src_e;

    function automatic src_e sel_source(input int idx, input logic [EVT_W-1:0] code,
                                        input logic run);
        src_e s;
        s = SRC_NONE;
        if (code == EV_INSN) s = SRC_INSN;
        else if (code == EV_CYC) s = SRC_CYC;
        else if (idx == 0 && code == EV_INSN_ALT) s = SRC_INSN;
        else if (idx == 0 && code == EV_CYC_ALT) s = SRC_CYC;
        else if (idx == 3 && code == EV_RUN_INSN && run) s = SRC_INSN;
        return s;
    endfunction
endpackage

// File: rtl/pcb_event_decode.sv
module pcb_event_decode
    import pcb_pkg::*;
(
    input  mode_t              mode,
    input  logic [SEL_W-1:0]   evsel,
    input  logic               run_latch,
    output logic [NUM_CTR-1:0] ins_en,
    output logic [NUM_CTR-1:0] cyc_en
);
    logic sel_gate;
    logic fix_gate;

    assign sel_gate = !mode.frz_all && !mode.frz_14 && (evsel != '0);
    assign fix_gate = !mode.frz_all && !mode.frz_56;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        src_e src;
        assign src       = sel_source(i, evsel[i*EVT_W +: EVT_W], run_latch);
        assign ins_en[i] = sel_gate && (src == SRC_INSN);
        assign cyc_en[i] = sel_gate && (src == SRC_CYC);
    end

    assign ins_en[NUM_SEL]   = fix_gate;
    assign cyc_en[NUM_SEL]   = 1'b0;
    assign ins_en[NUM_SEL+1] = 1'b0;
    assign cyc_en[NUM_SEL+1] = fix_gate;
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int CTR_W  = 32,
    parameter int INSN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_en,
    input  logic              cyc_en,
    input  logic [INSN_W-1:0] insn_cnt,
    input  logic              cyc_tick,
    input  logic              ovf_en,
    input  logic              wr_en,
    input  logic [CTR_W-1:0]  wr_val,
    output logic [CTR_W-1:0]  value,
    output logic              ovf_hit
);
    localparam int INC_W = INSN_W + 1;
    localparam logic [CTR_W:0] THRESH = (CTR_W+1)'(1) << (CTR_W - 1);

    logic [INC_W-1:0] inc;
    logic [CTR_W:0]   sum;

    always_comb begin
        inc = '0;
        if (ins_en) inc = {1'b0, insn_cnt};
        else if (cyc_en && cyc_tick) inc = INC_W'(1);
        sum = {1'b0, value} + (CTR_W+1)'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            ovf_hit <= 1'b0;
        end else begin
            ovf_hit <= 1'b0;
            if (wr_en) begin
                value <= wr_val;
            end else if (inc != '0) begin
                if (ovf_en && sum >= THRESH) begin
                    value   <= THRESH[CTR_W-1:0];
                    ovf_hit <= 1'b1;
                end else begin
                    value <= sum[CTR_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSN_W-1:0]  insn_cnt,
    input  logic               cyc_tick,
    input  logic               run_latch,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [CTR_W-1:0]   reg_rdata,
    output logic               ovf_pulse
);
    mode_t              mode_q;
    logic [SEL_W-1:0]   evsel_q;
    logic [NUM_CTR-1:0] ins_en;
    logic [NUM_CTR-1:0] cyc_en;
    logic [NUM_CTR-1:0] hit;
    logic [CTR_W-1:0]   cnt [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            evsel_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MODE)  mode_q  <= mode_t'(reg_wdata[MODE_W-1:0]);
            if (reg_addr == ADDR_EVENT) evsel_q <= reg_wdata[SEL_W-1:0];
        end
    end

    pcb_event_decode u_dec (
        .mode      (mode_q),
        .evsel     (evsel_q),
        .run_latch (run_latch),
        .ins_en    (ins_en),
        .cyc_en    (cyc_en)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic wr_i;
        logic ovf_en_i;
        assign wr_i     = reg_wr && (reg_addr == ADDR_W'(i));
        assign ovf_en_i = (i == 0) ? mode_q.ovf_en_first : mode_q.ovf_en_rest;

        pcb_counter #(.CTR_W(CTR_W), .INSN_W(INSN_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .ins_en   (ins_en[i]),
            .cyc_en   (cyc_en[i]),
            .insn_cnt (insn_cnt),
            .cyc_tick (cyc_tick),
            .ovf_en   (ovf_en_i),
            .wr_en    (wr_i),
            .wr_val   (reg_wdata[CTR_W-1:0]),
            .value    (cnt[i]),
            .ovf_hit  (hit[i])
        );
        assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
    end

    assign ovf_pulse = |hit;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++)
            if (reg_addr == ADDR_W'(i)) reg_rdata = cnt[i];
        if (reg_addr == ADDR_MODE)  reg_rdata = CTR_W'(mode_q);
        if (reg_addr == ADDR_EVENT) reg_rdata = CTR_W'(evsel_q);
    end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input mode_t                    mode,
    input logic                     reg_wr,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [WDATA_W-1:0]       reg_wdata,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic                     ovf_pulse
);
    localparam logic [CTR_W-1:0] SAT = CTR_W'(1) << (CTR_W - 1);

    logic              past_ok;
    logic              cnt_wr;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CTR_W-1:0]  data_q;
    logic [CTR_W-1:0]  picked;
    logic              any_sat;

    assign cnt_wr = reg_wr && (reg_addr < ADDR_W'(NUM_CTR));

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            past_ok <= 1'b1;
            wr_q    <= cnt_wr;
            addr_q  <= reg_addr;
            data_q  <= reg_wdata[CTR_W-1:0];
        end
    end

    always_comb begin
        picked  = '0;
        any_sat = 1'b0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr_q == ADDR_W'(i)) picked = cnt_flat[i*CTR_W +: CTR_W];
            if (cnt_flat[i*CTR_W +: CTR_W] == SAT) any_sat = 1'b1;
        end
    end

    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(mode.frz_all) && !$past(cnt_wr) |-> $stable(cnt_flat));

    assert_pulse_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        past_ok && ovf_pulse |-> $past(mode.ovf_en_first || mode.ovf_en_rest));

    assert_pulse_clamped_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> any_sat);

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        past_ok && wr_q |-> picked == data_q);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !ovf_pulse);
endmodule

bind perf_counter_bank pcb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cnt_flat  (cnt_flat),
    .ovf_pulse (ovf_pulse)
);

// File: tb/perf_counter_bank_test.sv
`timescale 1ns/1ps
module perf_counter_bank_test;
    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  insn_cnt = '0;
    logic        cyc_tick = 1'b0;
    logic        run_latch = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ovf_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] m_cnt [6];
    logic [4:0]  m_mode = '0;
    logic [31:0] m_sel  = '0;

    always #(PERIOD/2) clk = ~clk;

    perf_counter_bank uut (
        .clk(clk), .rst(rst), .insn_cnt(insn_cnt), .cyc_tick(cyc_tick),
        .run_latch(run_latch), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pulse(ovf_pulse)
    );

    // 0 none, 1 instructions, 2 cycles: per R3..R8
    function automatic int src_of(int k, logic run);
        logic [7:0] c;
        if (m_mode[0]) return 0;
        if (k == 4) return m_mode[2] ? 0 : 1;
        if (k == 5) return m_mode[2] ? 0 : 2;
        if (m_mode[1] || m_sel == 0) return 0;
        c = m_sel[8*k +: 8];
        if (c == 8'h02) return 1;
        if (c == 8'h1E) return 2;
        if (k == 0 && c == 8'hFE) return 1;
        if (k == 0 && c == 8'hF0) return 2;
        if (k == 3 && c == 8'hFA && run) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(logic [3:0] a);
        if (a < 6) return m_cnt[a];
        if (a == 6) return {27'd0, m_mode};
        if (a == 7) return m_sel;
        return 32'd0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic wr, logic [3:0] a, logic [63:0] wd,
                        logic [2:0] ins, logic tk, logic run);
        logic [31:0] nxt [6];
        logic        pulse;
        logic [32:0] sum;
        int          s;
        logic [3:0]  inc;
        logic        en;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        insn_cnt = ins; cyc_tick = tk; run_latch = run;
        pulse = 1'b0;
        for (int k = 0; k < 6; k++) begin
            s   = src_of(k, run);
            inc = (s == 1) ? {1'b0, ins} : (s == 2) ? {3'd0, tk} : 4'd0;
            nxt[k] = m_cnt[k];
            en  = (k == 0) ? m_mode[3] : m_mode[4];
            sum = {1'b0, m_cnt[k]} + 33'(inc);
            if (wr && a == 4'(k)) nxt[k] = wd[31:0];
            else if (inc != 0) begin
                if (en && sum >= 33'h0_8000_0000) begin
                    nxt[k] = 32'h8000_0000;
                    pulse  = 1'b1;
                end else nxt[k] = sum[31:0];
            end
        end
        @(posedge clk);
        for (int k = 0; k < 6; k++) m_cnt[k] = nxt[k];
        if (wr && a == 6) m_mode = wd[4:0];
        if (wr && a == 7) m_sel = wd[31:0];
        #1;
        check(tag, reg_rdata, model_read(a));
        check({tag, " R9 pulse"}, {31'd0, ovf_pulse}, {31'd0, pulse});
    endtask

    task automatic wreg(logic [3:0] a, logic [63:0] v);
        step("R2 write", 1'b1, a, v, 3'd0, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] rnd_code();
        case ($urandom % 7)
            0: return 8'h00; 1: return 8'h02; 2: return 8'hFE; 3: return 8'h1E;
            4: return 8'hF0; 5: return 8'hFA; default: return 8'h55;
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] wd;
        logic [3:0]  a;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 6; k++) m_cnt[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of every register
        for (int i = 0; i < 9; i++) step("R1", 1'b0, 4'(i), 64'd0, 3'd0, 1'b0, 1'b0);

        // R8: fixed-function counters 5 and 6; R12 timing
        step("R8 R12", 1'b0, 4'd4, 64'd0, 3'd3, 1'b1, 1'b0);
        step("R8", 1'b0, 4'd5, 64'd0, 3'd6, 1'b1, 1'b0);
        wreg(4'd6, 64'h4);
        step("R8 freeze56", 1'b0, 4'd4, 64'd0, 3'd7, 1'b1, 1'b0);

        // R3: freeze all
        wreg(4'd7, 64'h1E02_02FE);
        wreg(4'd6, 64'h1);
        for (int i = 0; i < 6; i++) step("R3", 1'b0, 4'(i), 64'd0, 3'd7, 1'b1, 1'b1);

        // R4: freeze 1-4 and empty event register
        wreg(4'd6, 64'h2);
        step("R4 frz14", 1'b0, 4'd0, 64'd0, 3'd5, 1'b1, 1'b0);
        wreg(4'd6, 64'h0);
        wreg(4'd7, 64'h0);
        step("R4 zero sel", 1'b0, 4'd0, 64'd0, 3'd5, 1'b1, 1'b0);

        // R5 R6 R7: event codes
        wreg(4'd7, 64'h0000_00FE);
        step("R5 FE", 1'b0, 4'd0, 64'd0, 3'd4, 1'b1, 1'b0);
        wreg(4'd7, 64'h0000_00F0);
        step("R5 F0", 1'b0, 4'd0, 64'd0, 3'd4, 1'b1, 1'b0);
        wreg(4'd7, 64'h0002_1E00);
        step("R6 c2", 1'b0, 4'd1, 64'd0, 3'd2, 1'b1, 1'b0);
        step("R6 c3", 1'b0, 4'd2, 64'd0, 3'd2, 1'b1, 1'b0);
        wreg(4'd7, 64'hFA00_0000);
        step("R7 FA low", 1'b0, 4'd3, 64'd0, 3'd5, 1'b1, 1'b0);
        step("R7 FA high", 1'b0, 4'd3, 64'd0, 3'd5, 1'b1, 1'b1);
        wreg(4'd7, 64'hFE00_0000);
        step("R8 other code", 1'b0, 4'd3, 64'd0, 3'd5, 1'b1, 1'b1);

        // R9: saturation on counter 1 with its own enable
        wreg(4'd6, 64'h8);
        wreg(4'd7, 64'h0000_0202);
        wreg(4'd0, 64'h7FFF_FFFE);
        step("R9 clamp", 1'b0, 4'd0, 64'd0, 3'd3, 1'b0, 1'b0);
        step("R9 again", 1'b0, 4'd0, 64'd0, 3'd1, 1'b0, 1'b0);
        // R10: counter 2 not enabled by bit 3
        wreg(4'd1, 64'h7FFF_FFFF);
        step("R10 c2 pass", 1'b0, 4'd1, 64'd0, 3'd2, 1'b0, 1'b0);
        wreg(4'd6, 64'h0);
        wreg(4'd4, 64'hFFFF_FFFF);
        step("R10 wrap", 1'b0, 4'd4, 64'd0, 3'd2, 1'b0, 1'b0);
        // R9 shared enable for counter 5
        wreg(4'd6, 64'h10);
        wreg(4'd4, 64'h7FFF_FFFA);
        step("R9 c5", 1'b0, 4'd4, 64'd0, 3'd7, 1'b0, 1'b0);

        // R11: write priority and low 32 bits
        step("R11", 1'b1, 4'd4, 64'hABCD_0000_1234_5678, 3'd7, 1'b1, 1'b0);
        step("R11 sat", 1'b1, 4'd0, 64'hFFFF_FFFF_7FFF_FFFF, 3'd7, 1'b0, 1'b0);
        // R2: unmapped address and mode width
        step("R2 unmapped", 1'b1, 4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 1'b0, 1'b0);
        wreg(4'd6, 64'hFFFF_FFE0);
        step("R2 mode", 1'b0, 4'd6, 64'd0, 3'd0, 1'b0, 1'b0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic w;
            w = ($urandom % 6) == 0;
            a = 4'($urandom % 9);
            wd = {$urandom, $urandom};
            if (w && a < 6 && ($urandom % 2)) wd = 64'h7FFF_FFF0 + 64'($urandom % 24);
            if (w && a == 6) wd = 64'($urandom % 32) & (($urandom % 3) == 0 ? 64'h1F : 64'h1E);
            if (w && a == 7) wd = {32'd0, rnd_code(), rnd_code(), rnd_code(), rnd_code()};
            step("R12 random", w, a, wd, 3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule